// File: doc/BRIEF.md
# Multi-Level Link Transmit Calibration Sequencer

This block calibrates a multi-level signalling link whose sender is a fine-resolution DAC and whose receiver is a coarser ADC with imperfect decision thresholds. The ADC cannot be changed, so all correction happens on the sending side. When started, the sequencer drives every DAC input code once, in ascending order. After each step it waits a programmable settle time and then records which ADC code came back.

For each ADC output code, the sequencer keeps the lowest and the highest DAC code that decoded to it. At the end of the sweep it writes the midpoint of that run into a transmit lookup table. Because the converter pair is taken to be monotonic, the DAC codes that decode to one ADC code form a single contiguous run. The midpoint, rounded down, is therefore the median of that group, which gives the widest margin against noise on both sides.

In normal operation a symbol of ADC_W bits (5 bits, 32 levels, by default) is presented on the lookup port and the calibrated DAC code is returned. An ADC code that never appears during the sweep keeps an evenly spaced default entry, raises its own missing flag and raises a calibration-error output.

Top module: `mvl_cal_seq`

## Requirements
- R1: After reset, busy, done and cal_error are 0, dac_code is 0, every missing bit is 0, and table entry i holds i * 2^(DAC_W-ADC_W).
- R2: A start pulse while idle begins a sweep with busy high. During the sweep dac_code takes every value from 0 to 2^DAC_W-1 exactly once, rising by one at each change. A start pulse while busy has no effect on the sweep.
- R3: After each dac_code change, the ADC result is taken no earlier than the edge that follows settle+1 full cycles of a stable dac_code. The settle value is captured at start.
- R4: After the settle time, the sequencer holds dac_code until adc_valid is high, and takes adc_code on that edge.
- R5: For each ADC code seen during the sweep, the table entry becomes floor((first+last)/2), where first and last are the lowest and highest DAC codes that decoded to that code.
- R6: For each ADC code never seen, missing[code] is 1, the table entry keeps the default code * 2^(DAC_W-ADC_W), and cal_error is 1. Both flags are cleared by the next start.
- R7: When the sweep ends, done goes to 1, busy goes to 0 and dac_code returns to 0. A start clears done.
- R8: lk_code always equals the table entry selected by lk_sym, with no clock delay. While a sweep runs, the table keeps its previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration sweep (used only when idle) |
| settle | input | SETTLE_W | Extra settle cycles per DAC step, captured at start |
| dac_code | output | DAC_W | Code driven to the DAC |
| adc_code | input | ADC_W | Decoded code returned by the ADC |
| adc_valid | input | 1 | adc_code is valid this cycle |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Last sweep completed |
| cal_error | output | 1 | Last sweep left at least one ADC code unseen |
| missing | output | 2^ADC_W | Per-code flag: code never observed |
| lk_sym | input | ADC_W | Transmit symbol to map |
| lk_code | output | DAC_W | Calibrated DAC code for lk_sym |

## Verification
The bench builds the block with its defaults: an 8-bit DAC against a 5-bit ADC, so a full sweep of 256 steps finishes in a few thousand cycles. Every table entry and every missing flag can then be compared after each sweep. The ADC model in the bench returns a wrong code until the DAC has been stable for the settle time, so sampling even one edge early corrupts the table. The runs cover a uniform transfer curve, a strongly nonlinear square-law curve with bins of very different widths, a curve with one code skipped, and a run where adc_valid is withheld on some cycles.

// File: rtl/mvl_cal_seq.sv
module mvl_cal_seq #(
  parameter int DAC_W    = 8,
  parameter int ADC_W    = 5,
  parameter int SETTLE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [SETTLE_W-1:0]   settle,
  output logic [DAC_W-1:0]      dac_code,
  input  logic [ADC_W-1:0]      adc_code,
  input  logic                  adc_valid,
  output logic                  busy,
  output logic                  done,
  output logic                  cal_error,
  output logic [(1<<ADC_W)-1:0] missing,
  input  logic [ADC_W-1:0]      lk_sym,
  output logic [DAC_W-1:0]      lk_code
);

  localparam int NSYM  = 1 << ADC_W;
  localparam int SHIFT = DAC_W - ADC_W;
  localparam logic [DAC_W-1:0] DAC_MAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_WAIT, S_FINAL} state_t;

  state_t              state;
  logic [SETTLE_W-1:0] cnt, settle_q;
  logic [NSYM-1:0]     seen;
  logic [DAC_W-1:0]    lo_tab  [NSYM];
  logic [DAC_W-1:0]    hi_tab  [NSYM];
  logic [DAC_W-1:0]    lut     [NSYM];

  assign busy    = (state != S_IDLE);
  assign lk_code = lut[lk_sym];

  function automatic logic [DAC_W-1:0] mid_of(input logic [DAC_W-1:0] a, input logic [DAC_W-1:0] b);
    logic [DAC_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[DAC_W:1];
  endfunction

  function automatic logic [DAC_W-1:0] dflt(input int i);
    return DAC_W'(i << SHIFT);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      settle_q  <= '0;
      dac_code  <= '0;
      seen      <= '0;
      done      <= 1'b0;
      cal_error <= 1'b0;
      missing   <= '0;
      for (int i = 0; i < NSYM; i++) begin
        lo_tab[i] <= '0;
        hi_tab[i] <= '0;
        lut[i]    <= dflt(i);
      end
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state     <= S_SETTLE;
          settle_q  <= settle;
          cnt       <= '0;
          dac_code  <= '0;
          seen      <= '0;
          done      <= 1'b0;
          cal_error <= 1'b0;
          missing   <= '0;
        end
        S_SETTLE: begin
          if (cnt == settle_q) state <= S_WAIT;
          else                 cnt   <= cnt + 1'b1;
        end
        S_WAIT: if (adc_valid) begin
          if (!seen[adc_code]) begin
            lo_tab[adc_code] <= dac_code;
            seen[adc_code]   <= 1'b1;
          end
          hi_tab[adc_code] <= dac_code;
          if (dac_code == DAC_MAX) begin
            state <= S_FINAL;
          end else begin
            dac_code <= dac_code + 1'b1;
            cnt      <= '0;
            state    <= S_SETTLE;
          end
        end
        S_FINAL: begin
          for (int i = 0; i < NSYM; i++)
            lut[i] <= seen[i] ? mid_of(lo_tab[i], hi_tab[i]) : dflt(i);
          missing   <= ~seen;
          cal_error <= ~&seen;
          done      <= 1'b1;
          dac_code  <= '0;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_DAC_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && dac_code != $past(dac_code)) |-> dac_code == $past(dac_code) + 1'b1); // R2

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state != S_FINAL && start) |=> (busy && !done)); // R2

  AST_NO_EARLY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && !adc_valid) |=> $stable(dac_code)); // R4

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && dac_code == '0)); // R7

  AST_ERR_MATCHES_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (cal_error == (missing != '0))); // R6

  AST_LUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(lk_sym)) |-> $stable(lk_code)); // R8

endmodule

// File: tb/test_mvl_cal_seq.sv
module test_mvl_cal_seq;
  localparam int DAC_W = 8, ADC_W = 5, SETTLE_W = 8;
  localparam int NSYM = 32, NDAC = 256;

  logic clk = 0, rst_n = 0, start = 0, adc_valid = 0;
  logic [SETTLE_W-1:0] settle = 0;
  logic [DAC_W-1:0] dac_code, lk_code;
  logic [ADC_W-1:0] adc_code = 0, lk_sym = 0;
  logic busy, done, cal_error;
  logic [NSYM-1:0] missing;

  mvl_cal_seq #(.DAC_W(DAC_W), .ADC_W(ADC_W), .SETTLE_W(SETTLE_W)) i_mvl_cal_seq (
    .clk, .rst_n, .start, .settle, .dac_code, .adc_code, .adc_valid,
    .busy, .done, .cal_error, .missing, .lk_sym, .lk_code);

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  int mode = 0, age = 0, prev_dac = 0, gate = 0;
  int bad_steps = 0, n_steps = 0;
  int exp_lut [NSYM];
  int exp_miss[NSYM];

  function automatic int fmap(int m, int d);
    int c;
    case (m)
      1: c = (d * d) >> 11;
      2: begin c = d >> 3; if (c == 7) c = 6; end
      default: c = d >> 3;
    endcase
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build_expected(input int m);
    for (int c = 0; c < NSYM; c++) begin
      int lo, hi;
      lo = -1; hi = -1;
      for (int d = 0; d < NDAC; d++)
        if (fmap(m, d) == c) begin
          if (lo < 0) lo = d;
          hi = d;
        end
      exp_miss[c] = (lo < 0);
      exp_lut[c]  = (lo < 0) ? c * 8 : (lo + hi) / 2;
    end
  endtask

  // ADC model: wrong code until dac_code has been stable for more than settle cycles
  always @(negedge clk) begin
    if (int'(dac_code) != prev_dac) begin
      age = 0;
      if (busy) begin
        n_steps++;
        if (int'(dac_code) != prev_dac + 1) bad_steps++;
      end
    end else age++;
    prev_dac = int'(dac_code);
    gate++;
    adc_code  = (age > int'(settle))
                ? ADC_W'(fmap(mode, int'(dac_code)))
                : ADC_W'(fmap(mode, int'(dac_code)) + 16);
    adc_valid = (mode == 3) ? ((gate % 3) != 1) : 1'b1;
  end

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic run_sweep(input int m, input int st, input string tag);
    int wd;
    mode = m; settle = SETTLE_W'(st);
    bad_steps = 0; n_steps = 0;
    build_expected(m == 3 ? 0 : m);
    pulse_start();
    chk(busy == 1 && done == 0, "R2 busy after start", busy, 1);
    wd = 0;
    while (!done && wd < 20000) begin @(negedge clk); wd++; end
    chk(wd < 20000, "R7 watchdog", wd, 20000);
    chk(bad_steps == 0 && n_steps == NDAC - 1, "R2 ascending single-step sweep", n_steps, NDAC - 1);
    chk(busy == 0 && dac_code == 0, "R7 idle after done", int'(dac_code), 0);
    for (int c = 0; c < NSYM; c++) begin
      lk_sym = ADC_W'(c);
      #1;
      chk(int'(lk_code) == exp_lut[c], $sformatf("R5 %s entry %0d", tag, c), int'(lk_code), exp_lut[c]);
      chk(missing[c] == exp_miss[c][0], $sformatf("R6 %s missing %0d", tag, c), int'(missing[c]), exp_miss[c]);
    end
    chk(cal_error == (m == 2), $sformatf("R6 %s cal_error", tag), int'(cal_error), int'(m == 2));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && cal_error == 0, "R1 status", {busy, done, cal_error}, 0);
    chk(dac_code == 0 && missing == 0, "R1 dac/missing", int'(dac_code), 0);
    for (int c = 0; c < NSYM; c++) begin
      lk_sym = ADC_W'(c); #1;
      chk(int'(lk_code) == c * 8, "R1 default entry", int'(lk_code), c * 8);
    end
    rst_n = 1;
    @(negedge clk);

    run_sweep(0, 2, "R3 uniform settle2");
    run_sweep(1, 5, "R5 square-law");
    run_sweep(2, 0, "R6 skipped-code");

    // next start clears error and done; table held during sweep
    mode = 3; settle = SETTLE_W'(1);
    lk_sym = ADC_W'(6);
    pulse_start();
    chk(cal_error == 0 && missing == 0 && done == 0, "R6 flags cleared by start", int'(cal_error), 0);
    repeat (40) @(negedge clk);
    chk(int'(lk_code) == 55, "R8 table held while busy", int'(lk_code), 55);
    // start while busy ignored
    start = 1; @(negedge clk); start = 0;
    chk(busy == 1 && dac_code != 0, "R2 start while busy ignored", int'(dac_code), 1);
    begin
      int wd;
      wd = 0;
      while (!done && wd < 20000) begin @(negedge clk); wd++; end
      chk(wd < 20000, "R4 watchdog", wd, 20000);
    end
    build_expected(0);
    for (int c = 0; c < NSYM; c++) begin
      lk_sym = ADC_W'(c); #1;
      chk(int'(lk_code) == exp_lut[c], "R4 gated-valid entry", int'(lk_code), exp_lut[c]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #8000000;
    errors++; checks++;
    $display("FAIL R7 global watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule